// File: doc/BRIEF.md
# Status Register Masked Write Unit

This block keeps the processor's current status word, plus one saved status word for each exception bank that owns one. A move-to-status instruction writes to either the current word or the saved word of the active bank. Four field-enable bits, one per byte, pick which bytes change. Bytes that are not enabled keep their old contents. The active bank is decoded from the mode field of the current word.

When the core runs in user mode, only the top (flags) byte of the current word can be written. Writes to a saved word are dropped when the active bank has none; this applies to user, system and undecoded modes. A read of the saved word in such a bank returns the current word. When the 32-bit-program input is low, a value written to the current word is reduced to the fields that the legacy 26-bit program model keeps.

When a write changes the mode field, the block raises a one-cycle strobe that carries the old and new modes to the external register bank. It also drives the unpacked flags, the interrupt disables and the mode.

Top module: `psr_write_unit`

## Requirements
- R1: After reset the current word is 0x000000D3 (supervisor mode 0x13, IRQ and FIQ disabled), every saved word is zero and the mode strobe is low.
- R2: Field mask bit 0 enables byte [7:0], bit 1 enables byte [15:8], bit 2 enables byte [23:16] and bit 3 enables byte [31:24]. A byte whose bit is clear keeps its old value. A write takes effect at the clock edge that samples `wr_en` high.
- R3: In user mode (0x10 or 0x00), a write to the current word changes only byte [31:24]. The other three enables are ignored.
- R4: A write with `wr_to_saved` high updates the saved word of the active bank. Only the FIQ (0x11/0x01), IRQ (0x12/0x02), supervisor (0x13/0x03), abort (0x17) and undefined (0x1B) banks own a saved word. In every other mode the write changes nothing.
- R5: `saved_psr` shows the saved word of the active bank. For a bank without one, it shows the current word.
- R6: While `prog32` is low, a value written to the current word keeps only bits 31:28, 7:6 and 1:0. All other bits become zero.
- R7: Bits 27:24 are reserved. They always read as zero in both the current and the saved words.
- R8: The flag outputs follow the current word: N = bit 31, Z = bit 30, C = bit 29, V = bit 28, IRQ disable = bit 7, FIQ disable = bit 6, mode = bits 4:0.
- R9: A current-word write that changes the mode field drives `mode_chg` high for exactly the following cycle, with `mode_old`/`mode_new` holding the two modes. When no mode change is written, the strobe stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Perform a move-to-status write this cycle |
| wr_to_saved | input | 1 | 1 = target the saved word, 0 = the current word |
| field_mask | input | 4 | Byte enables taken from instruction bits 19:16 |
| wr_data | input | 32 | Source value |
| prog32 | input | 1 | 32-bit program model; low applies the 26-bit mask |
| cur_psr | output | 32 | Current status word |
| saved_psr | output | 32 | Saved word of the active bank, or the current word |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |
| irq_dis | output | 1 | IRQ disable |
| fiq_dis | output | 1 | FIQ disable |
| mode | output | 5 | Current mode field |
| mode_chg | output | 1 | One-cycle mode-change strobe to the register bank |
| mode_old | output | 5 | Mode before the change |
| mode_new | output | 5 | Mode after the change |

## Verification
The assertions assume that `wr_en` is held low while reset is asserted. They also assume that the inputs settle well away from the rising edge. The user-mode privilege property is only checked while `prog32` is high, because the 26-bit mask may also clear lower bytes. The stimulus meets these conditions: every input changes on the falling edge, and reset is entered and left with `wr_en` low. Tests of 26-bit behaviour are kept in a separate phase that starts after a fresh reset.

// File: rtl/psr_pkg.sv
package psr_pkg;

    localparam int PSR_W      = 32;
    localparam int MODE_W     = 5;
    localparam int FIELDS     = PSR_W / 8;
    localparam int NUM_BANKS  = 8;

    localparam logic [PSR_W-1:0] RSV_BITS    = 32'h0F00_0000;
    localparam logic [PSR_W-1:0] LEGACY_KEEP = 32'hF000_00C3;
    localparam logic [PSR_W-1:0] PSR_RESET   = 32'h0000_00D3;

    localparam int BIT_N   = 31;
    localparam int BIT_Z   = 30;
    localparam int BIT_C   = 29;
    localparam int BIT_V   = 28;
    localparam int BIT_IRQ = 7;
    localparam int BIT_FIQ = 6;

    typedef enum logic [2:0] {
        BK_USR  = 3'd0,
        BK_FIQ  = 3'd1,
        BK_IRQ  = 3'd2,
        BK_SVC  = 3'd3,
        BK_ABT  = 3'd4,
        BK_UND  = 3'd5,
        BK_SYS  = 3'd6,
        BK_NONE = 3'd7
    } bank_e;

    typedef struct packed {
        logic              chg;
        logic [MODE_W-1:0] from_m;
        logic [MODE_W-1:0] to_m;
    } mode_evt_t;

    function automatic bank_e bank_of(input logic [MODE_W-1:0] m);
        case (m)
            5'h00, 5'h10: bank_of = BK_USR;
            5'h01, 5'h11: bank_of = BK_FIQ;
            5'h02, 5'h12: bank_of = BK_IRQ;
            5'h03, 5'h13: bank_of = BK_SVC;
            5'h17:        bank_of = BK_ABT;
            5'h1B:        bank_of = BK_UND;
            5'h1F:        bank_of = BK_SYS;
            default:      bank_of = BK_NONE;
        endcase
    endfunction

    function automatic logic owns_saved(input bank_e b);
        owns_saved = (b == BK_FIQ) || (b == BK_IRQ) || (b == BK_SVC) ||
                     (b == BK_ABT) || (b == BK_UND);
    endfunction

    function automatic logic [PSR_W-1:0] expand_mask(input logic [FIELDS-1:0] m);
        for (int i = 0; i < FIELDS; i++)
            expand_mask[i*8 +: 8] = {8{m[i]}};
    endfunction

endpackage

// File: rtl/psr_field_merge.sv
module psr_field_merge
    import psr_pkg::*;
(
    input  logic [PSR_W-1:0]  old_val,
    input  logic [PSR_W-1:0]  new_val,
    input  logic [FIELDS-1:0] field_en,
    input  logic              flags_only,
    input  logic              legacy,
    output logic [PSR_W-1:0]  merged
);
    logic [FIELDS-1:0] eff_en;
    logic [PSR_W-1:0]  bit_en;
    logic [PSR_W-1:0]  raw;

    always_comb begin
        eff_en = field_en;
        if (flags_only)
            eff_en = field_en & {1'b1, {(FIELDS-1){1'b0}}};
        bit_en = expand_mask(eff_en);
        raw    = (old_val & ~bit_en) | (new_val & bit_en);
        if (legacy)
            raw = raw & LEGACY_KEEP;
        merged = raw & ~RSV_BITS;
    end
endmodule

// File: rtl/psr_saved_file.sv
module psr_saved_file
    import psr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  bank_e            bank,
    input  logic             wr,
    input  logic [PSR_W-1:0] wdata,
    output logic [PSR_W-1:0] rdata,
    output logic             present
);
    logic [PSR_W-1:0] store [NUM_BANKS];

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        if (owns_saved(bank_e'(g))) begin : g_real
            always_ff @(posedge clk) begin
                if (rst)
                    store[g] <= '0;
                else if (wr && (bank == bank_e'(g)))
                    store[g] <= wdata;
            end
        end else begin : g_empty
            assign store[g] = '0;
        end
    end

    assign present = owns_saved(bank);
    assign rdata   = store[bank];

    assert_saved_rsv_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (rdata & RSV_BITS) == '0);
endmodule

// File: rtl/psr_mode_strobe.sv
module psr_mode_strobe
    import psr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  logic [MODE_W-1:0] cur_mode,
    input  logic [MODE_W-1:0] next_mode,
    output mode_evt_t         evt
);
    mode_evt_t evt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            evt_q <= '0;
        end else begin
            evt_q.chg    <= commit && (cur_mode != next_mode);
            evt_q.from_m <= cur_mode;
            evt_q.to_m   <= next_mode;
        end
    end

    assign evt = evt_q;

    assert_strobe_new_mode_R9: assert property (@(posedge clk) disable iff (rst)
        evt_q.chg |-> (evt_q.to_m == cur_mode) && (evt_q.from_m != evt_q.to_m));
    assert_strobe_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !$past(commit) |-> !evt_q.chg);
endmodule

// File: rtl/psr_write_unit.sv
module psr_write_unit
    import psr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_to_saved,
    input  logic [3:0]        field_mask,
    input  logic [31:0]       wr_data,
    input  logic              prog32,
    output logic [31:0]       cur_psr,
    output logic [31:0]       saved_psr,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_c,
    output logic              flag_v,
    output logic              irq_dis,
    output logic              fiq_dis,
    output logic [4:0]        mode,
    output logic              mode_chg,
    output logic [4:0]        mode_old,
    output logic [4:0]        mode_new
);
    logic [PSR_W-1:0] cur_q;
    logic [PSR_W-1:0] cur_next;
    logic [PSR_W-1:0] sv_rd;
    logic [PSR_W-1:0] sv_next;
    logic             sv_present;
    logic             cur_wr;
    logic             sv_wr;
    bank_e            act_bank;
    mode_evt_t        evt;

    assign act_bank = bank_of(cur_q[MODE_W-1:0]);
    assign cur_wr   = wr_en && !wr_to_saved;
    assign sv_wr    = wr_en && wr_to_saved;

    psr_field_merge u_cur_merge (
        .old_val    (cur_q),
        .new_val    (wr_data),
        .field_en   (field_mask),
        .flags_only (act_bank == BK_USR),
        .legacy     (!prog32),
        .merged     (cur_next)
    );

    psr_field_merge u_sv_merge (
        .old_val    (sv_rd),
        .new_val    (wr_data),
        .field_en   (field_mask),
        .flags_only (1'b0),
        .legacy     (1'b0),
        .merged     (sv_next)
    );

    psr_saved_file u_saved (
        .clk     (clk),
        .rst     (rst),
        .bank    (act_bank),
        .wr      (sv_wr),
        .wdata   (sv_next),
        .rdata   (sv_rd),
        .present (sv_present)
    );

    psr_mode_strobe u_strobe (
        .clk       (clk),
        .rst       (rst),
        .commit    (cur_wr),
        .cur_mode  (cur_q[MODE_W-1:0]),
        .next_mode (cur_next[MODE_W-1:0]),
        .evt       (evt)
    );

    always_ff @(posedge clk) begin
        if (rst)
            cur_q <= PSR_RESET;
        else if (cur_wr)
            cur_q <= cur_next;
    end

    assign cur_psr   = cur_q;
    assign saved_psr = sv_present ? sv_rd : cur_q;
    assign flag_n    = cur_q[BIT_N];
    assign flag_z    = cur_q[BIT_Z];
    assign flag_c    = cur_q[BIT_C];
    assign flag_v    = cur_q[BIT_V];
    assign irq_dis   = cur_q[BIT_IRQ];
    assign fiq_dis   = cur_q[BIT_FIQ];
    assign mode      = cur_q[MODE_W-1:0];
    assign mode_chg  = evt.chg;
    assign mode_old  = evt.from_m;
    assign mode_new  = evt.to_m;

    assert_user_low_bytes_R3: assert property (@(posedge clk) disable iff (rst)
        (cur_wr && prog32 && (act_bank == BK_USR)) |=>
            (cur_q[23:0] == $past(cur_q[23:0])));
    assert_no_saved_fallback_R5: assert property (@(posedge clk) disable iff (rst)
        !owns_saved(act_bank) |-> (saved_psr == cur_q));
    assert_saved_drop_R4: assert property (@(posedge clk) disable iff (rst)
        (sv_wr && !owns_saved(act_bank)) |=> $stable(cur_q));
    assert_legacy_mask_R6: assert property (@(posedge clk) disable iff (rst)
        (cur_wr && !prog32) |=> ((cur_q & ~LEGACY_KEEP) == '0));
    assert_cur_rsv_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (cur_q & RSV_BITS) == '0);
endmodule

// File: tb/test_psr_write_unit.sv
`timescale 1ns/1ps
module test_psr_write_unit;

    typedef struct {
        logic [31:0] cur;
        logic [31:0] sv;
        logic        chg;
        logic [4:0]  from_m;
        logic [4:0]  to_m;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_to_saved = 1'b0;
    logic [3:0]  field_mask = 4'h0;
    logic [31:0] wr_data = '0;
    logic        prog32 = 1'b1;
    logic [31:0] cur_psr, saved_psr;
    logic        flag_n, flag_z, flag_c, flag_v, irq_dis, fiq_dis;
    logic [4:0]  mode, mode_old, mode_new;
    logic        mode_chg;

    int n_cmp = 0;
    int n_bad = 0;
    exp_t q[$];
    logic [31:0] m_cur;
    logic [31:0] m_sv [8];

    always #2 clk = ~clk;

    psr_write_unit i_psr_write_unit (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_to_saved(wr_to_saved),
        .field_mask(field_mask), .wr_data(wr_data), .prog32(prog32),
        .cur_psr(cur_psr), .saved_psr(saved_psr),
        .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v),
        .irq_dis(irq_dis), .fiq_dis(fiq_dis), .mode(mode),
        .mode_chg(mode_chg), .mode_old(mode_old), .mode_new(mode_new)
    );

    function automatic int bk(input logic [4:0] m);
        case (m)
            5'h00, 5'h10: return 0;
            5'h01, 5'h11: return 1;
            5'h02, 5'h12: return 2;
            5'h03, 5'h13: return 3;
            5'h17: return 4;
            5'h1B: return 5;
            5'h1F: return 6;
            default: return 7;
        endcase
    endfunction

    function automatic logic has_sv(input int b);
        return (b >= 1) && (b <= 5);
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_cur = 32'h0000_00D3;
        for (int i = 0; i < 8; i++) m_sv[i] = '0;
    endtask

    // Driver: applies one cycle of stimulus and pushes the expected outcome
    task automatic op(input logic en, input logic to_sv, input logic [3:0] mk,
                      input logic [31:0] d, input logic p32, input string req);
        exp_t e;
        logic [31:0] bm, n;
        logic [3:0]  em;
        int b;
        @(negedge clk);
        wr_en = en; wr_to_saved = to_sv; field_mask = mk; wr_data = d; prog32 = p32;
        b = bk(m_cur[4:0]);
        e.chg = 1'b0; e.from_m = m_cur[4:0]; e.to_m = m_cur[4:0];
        if (en && to_sv) begin
            if (has_sv(b)) begin
                for (int i = 0; i < 4; i++) bm[i*8 +: 8] = {8{mk[i]}};
                m_sv[b] = ((m_sv[b] & ~bm) | (d & bm)) & 32'hF0FF_FFFF;
            end
        end else if (en) begin
            em = (b == 0) ? (mk & 4'b1000) : mk;
            for (int i = 0; i < 4; i++) bm[i*8 +: 8] = {8{em[i]}};
            n = (m_cur & ~bm) | (d & bm);
            if (!p32) n = n & 32'hF000_00C3;
            n = n & 32'hF0FF_FFFF;
            e.chg = (n[4:0] != m_cur[4:0]);
            e.to_m = n[4:0];
            m_cur = n;
        end
        e.cur = m_cur;
        b = bk(m_cur[4:0]);
        e.sv = has_sv(b) ? m_sv[b] : m_cur;
        e.req = req;
        q.push_back(e);
    endtask

    // Monitor: compares after every edge that has an outstanding expectation
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(e.req, "cur_psr", cur_psr, e.cur);
            check(e.req, "saved_psr", saved_psr, e.sv);
            check("R8", "flags", {26'd0, flag_n, flag_z, flag_c, flag_v, irq_dis, fiq_dis},
                  {26'd0, e.cur[31:28], e.cur[7:6]});
            check("R8", "mode", {27'd0, mode}, {27'd0, e.cur[4:0]});
            check("R9", "mode_chg", {31'd0, mode_chg}, {31'd0, e.chg});
            if (e.chg)
                check("R9", "mode_old/new", {22'd0, mode_old, mode_new},
                      {22'd0, e.from_m, e.to_m});
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0; prog32 = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        #1;
        check("R1", "reset cur", cur_psr, 32'h0000_00D3);
        check("R1", "reset saved", saved_psr, 32'h0000_0000);
        check("R1", "reset strobe", {31'd0, mode_chg}, 32'd0);
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        model_reset();
        do_reset();
        // R2 byte fields, one at a time, in supervisor mode
        op(1, 0, 4'b1000, 32'hA000_0000, 1, "R2");
        op(1, 0, 4'b0100, 32'h00AB_0000, 1, "R2");
        op(1, 0, 4'b0010, 32'h0000_CD00, 1, "R2");
        op(1, 1, 4'b1111, 32'h5F00_1234, 1, "R4");
        op(1, 0, 4'b1111, 32'hFFFF_FFD3, 1, "R7");
        op(0, 0, 4'b1111, 32'hFFFF_FFFF, 1, "R2");
        // mode changes and bank-selected saved words
        op(1, 0, 4'b0001, 32'h0000_0092, 1, "R9");
        op(1, 1, 4'b0001, 32'h0000_0055, 1, "R4");
        op(1, 0, 4'b0001, 32'h0000_00D3, 1, "R5");
        op(1, 0, 4'b0001, 32'h0000_0010, 1, "R9");
        op(1, 0, 4'b1111, 32'h0000_0013, 1, "R3");
        op(1, 1, 4'b1111, 32'h1234_5678, 1, "R4");
        op(1, 0, 4'b0111, 32'h00FF_FF1F, 1, "R3");
        op(0, 0, 4'b0000, 32'h0, 1, "R9");
        // system mode: no saved word
        do_reset();
        op(1, 0, 4'b0001, 32'h0000_00DF, 1, "R9");
        op(1, 1, 4'b1111, 32'hCAFE_F00D, 1, "R5");
        op(1, 0, 4'b0001, 32'h0000_0013, 1, "R9");
        op(1, 0, 4'b1111, 32'hFFFF_FFFF, 0, "R6");
        op(1, 0, 4'b1111, 32'h5555_5501, 0, "R6");
        op(1, 1, 4'b1111, 32'h8000_0011, 1, "R4");
        op(1, 0, 4'b0001, 32'h0000_0000, 0, "R3");
        op(1, 0, 4'b1111, 32'h9000_00C3, 0, "R3");
        op(0, 0, 4'b0000, 32'h0, 1, "R9");
        // undecoded mode falls back to the current word
        do_reset();
        op(1, 0, 4'b0001, 32'h0000_0015, 1, "R5");
        op(1, 1, 4'b1111, 32'h1111_1111, 1, "R4");
        op(1, 0, 4'b0001, 32'h0000_0017, 1, "R9");
        op(1, 1, 4'b1001, 32'hBEEF_0077, 1, "R4");
        op(0, 0, 4'b0000, 32'h0, 1, "R5");
        repeat (3) @(posedge clk);
        #1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule